// File: doc/BRIEF.md
# Trigger-Controlled Up/Down Counter

This block is a timer counter whose source of count pulses is picked by one mode field. It has three internal-clock modes. In the first the counter steps on every system clock. In the second a trigger input acts as a level gate. In the third a rising trigger edge arms the counter, which then stays running. Three encoder modes exist as well. In those the counter steps only on edges of two quadrature inputs, and the system clock no longer advances it. The internal-clock sources and the encoder sources never act together. The count wraps inside the range 0 to a programmable top value.

Software drives a plain register port. A write strobe, a 2-bit address and write data load three fields: the mode, the direction bit and the top value. Read data is combinational on the address. Address 3 is a read-only status word that reports the active internal-clock mode, or flags that no such mode is active. The register port and the pins are plain control signals. There is no valid/ready handshake and no back-pressure: a write takes effect at the clock edge on which it is strobed, and `count` is always valid. The trigger input and both encoder inputs may be asynchronous. Each one passes through a two-flop synchroniser before the block uses it.

Top module: `trig_updown_counter`

## Requirements
- R1: After reset the count is 0, the mode field reads 0, the direction bit reads 0 (up), the top value reads all ones and the status word (address 3) reads 0.
- R2: In mode 0 the count takes one step on every clock. The direction bit selects the step: 0 counts up, 1 counts down.
- R3: Any step up from a count equal to or above the top value loads 0. A step down from 0 loads the top value. Writing the top value never changes the count.
- R4: In mode 5 the count steps on each clock only while the synchronised trigger is high, and holds while it is low. A trigger level present at clock edge k first affects the count at edge k+2.
- R5: In mode 6 the count holds until the synchronised trigger rises. The rise arms a latch, and the count then steps on every clock. A rising edge sampled at edge k gives its first step at edge k+3. Later rising edges neither restart nor reset the count.
- R6: Any write to address 0 clears the arm latch of mode 6, including a write of the same value. The count then holds until the next rising edge.
- R7: In mode 1 the count steps once per edge of input A and ignores the clock and the direction bit. The step is up when A differs from B after the edge, and down otherwise.
- R8: In mode 2 the count steps once per edge of input B. The step is up when B equals A after the edge, and down otherwise.
- R9: In mode 3 every edge of A or B gives one step, so there are four steps per encoder cycle, with direction as in R7 and R8. A cycle in which both synchronised inputs change gives no step. An encoder edge sampled at edge k gives its step at edge k+2.
- R10: Status word bits [2:0] hold the mode when the mode is 0, 5 or 6, and bit 3 is then 0. For every other mode, bit 3 is 1 and bits [2:0] are 0.
- R11: Mode values 4 and 7 leave the count frozen whatever the trigger, the encoder inputs and the clock do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mode, 1 direction, 2 top value, 3 status |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for cfg_addr |
| trig_in | input | 1 | External trigger, asynchronous |
| enc_a | input | 1 | Encoder input A, asynchronous |
| enc_b | input | 1 | Encoder input B, asynchronous |
| count | output | CNT_W | Current count |

## Verification
The bench targets the two wrap points, including a top value lowered below the running count. A design that compares with equality there would run on toward the full range instead of returning to 0. It pulses the trigger a second time in mode 6. A design that treats each edge as a restart would lose or zero the count. It also rewrites the same mode value, which must still disarm the latch. In quadrature it makes both inputs change together, which must give no step. A naive decoder would count such a change or flip the direction. It also reads the status word in every mode value, so a decoder that leaks encoder codes or unused codes as valid enable modes is caught.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 2;

  localparam logic [MODE_W-1:0] MODE_FREE  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_ENC_A = 3'd1;
  localparam logic [MODE_W-1:0] MODE_ENC_B = 3'd2;
  localparam logic [MODE_W-1:0] MODE_QUAD  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_GATED = 3'd5;
  localparam logic [MODE_W-1:0] MODE_EDGE  = 3'd6;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TOP    = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd3;

  localparam int STAT_INVALID_BIT = 3;

  function automatic logic is_clk_mode(input logic [MODE_W-1:0] m);
    return (m == MODE_FREE) || (m == MODE_GATED) || (m == MODE_EDGE);
  endfunction
endpackage

// File: rtl/tcnt_sync.sv
module tcnt_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dout_d
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0][WIDTH-1:0] pipe;

  for (genvar s = 0; s <= STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout   = pipe[STAGES-1];
  assign dout_d = pipe[STAGES];
endmodule

// File: rtl/tcnt_quad_dec.sv
module tcnt_quad_dec
  import tcnt_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              a,
  input  logic              b,
  input  logic              a_d,
  input  logic              b_d,
  output logic              step,
  output logic              up
);
  logic a_edge, b_edge, a_dir_up, b_dir_up;

  assign a_edge   = a ^ a_d;
  assign b_edge   = b ^ b_d;
  assign a_dir_up = a ^ b;     // A moved and now differs from B: forward
  assign b_dir_up = ~(a ^ b);  // B moved and now equals A: forward

  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    case (mode)
      MODE_ENC_A: begin step = a_edge; up = a_dir_up; end
      MODE_ENC_B: begin step = b_edge; up = b_dir_up; end
      MODE_QUAD: begin
        step = a_edge ^ b_edge;  // a double change carries no direction
        up   = a_edge ? a_dir_up : b_dir_up;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tcnt_core.sv
module tcnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             up,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    if (up) nxt = (count >= top) ? '0 : count + CNT_W'(1);
    else    nxt = (count == '0) ? top : count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= nxt;
  end
endmodule

// File: rtl/trig_updown_counter.sv
module trig_updown_counter
  import tcnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              trig_in,
  input  logic              enc_a,
  input  logic              enc_b,
  output logic [CNT_W-1:0]  count
);
  localparam int N_IN = 3;  // trigger, encoder A, encoder B

  logic [MODE_W-1:0] mode_q;
  logic              dir_q;
  logic [CNT_W-1:0]  top_q;
  logic              armed;
  logic [N_IN-1:0]   raw_in, sync_q, sync_d;
  logic              trig_s, trig_rise, mode_wr;
  logic              enc_step, enc_up, step, up;

  assign raw_in = {enc_b, enc_a, trig_in};

  tcnt_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_q), .dout_d(sync_d)
  );

  assign trig_s    = sync_q[0];
  assign trig_rise = sync_q[0] & ~sync_d[0];
  assign mode_wr   = cfg_we && (cfg_addr == ADDR_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      dir_q  <= 1'b0;
      top_q  <= '1;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADDR_MODE: mode_q <= cfg_wdata[MODE_W-1:0];
        ADDR_DIR:  dir_q  <= cfg_wdata[0];
        ADDR_TOP:  top_q  <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // arm latch for edge-started mode; a mode write always disarms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 armed <= 1'b0;
    else if (mode_wr)                           armed <= 1'b0;
    else if (mode_q == MODE_EDGE && trig_rise)  armed <= 1'b1;
  end

  tcnt_quad_dec u_dec (
    .mode(mode_q), .a(sync_q[1]), .b(sync_q[2]),
    .a_d(sync_d[1]), .b_d(sync_d[2]), .step(enc_step), .up(enc_up)
  );

  always_comb begin
    up = ~dir_q;
    case (mode_q)
      MODE_FREE:  step = 1'b1;
      MODE_GATED: step = trig_s;
      MODE_EDGE:  step = armed;
      MODE_ENC_A, MODE_ENC_B, MODE_QUAD: begin
        step = enc_step;
        up   = enc_up;
      end
      default:    step = 1'b0;
    endcase
  end

  tcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .up(up), .top(top_q), .count(count)
  );

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      ADDR_MODE: cfg_rdata[MODE_W-1:0] = mode_q;
      ADDR_DIR:  cfg_rdata[0]          = dir_q;
      ADDR_TOP:  cfg_rdata[CNT_W-1:0]  = top_q;
      default: begin
        if (is_clk_mode(mode_q)) cfg_rdata[MODE_W-1:0]      = mode_q;
        else                     cfg_rdata[STAT_INVALID_BIT] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/tcnt_checker.sv
module tcnt_checker
  import tcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [3:0]        stat_bits,
  input logic [CNT_W-1:0]  count,
  input logic [MODE_W-1:0] mode_q,
  input logic              dir_q,
  input logic [CNT_W-1:0]  top_q,
  input logic              trig_s,
  input logic              armed
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> count == '0);

  p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FREE && !dir_q && count == top_q) |=> count == '0);

  p_wrap_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FREE && dir_q && count == '0) |=> count == $past(top_q));

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_GATED && !trig_s) |=> $stable(count));

  p_arm_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(cfg_we && cfg_addr == ADDR_MODE)) |=> armed);

  p_mode_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_MODE) |=> !armed);

  p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_STATUS && !is_clk_mode(mode_q)) |-> stat_bits == 4'b1000);

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd4 || mode_q == 3'd7) |=> $stable(count));
endmodule

bind trig_updown_counter tcnt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .stat_bits(cfg_rdata[3:0]), .count(count), .mode_q(mode_q), .dir_q(dir_q),
  .top_q(top_q), .trig_s(trig_s), .armed(armed)
);

// File: tb/trig_updown_counter_bench.sv
`timescale 1ns/1ps
module trig_updown_counter_bench;
  localparam int CW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          trig_in = 1'b0, enc_a = 1'b0, enc_b = 1'b0;
  logic [CW-1:0] count;

  int checks = 0, errors = 0, cycles = 0;
  bit run_cmp = 1'b0;

  trig_updown_counter #(.CNT_W(CW), .DATA_W(DW)) u_trig_updown_counter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig_in(trig_in),
    .enc_a(enc_a), .enc_b(enc_b), .count(count)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  // ---------------- reference model built from the requirements ----------
  logic [2:0]    m_mode;
  logic          m_dir, m_armed;
  logic [CW-1:0] m_top, m_cnt;
  logic          t1, t2, t3, a1, a2, a3, b1, b2, b3;
  logic          m_stp, m_up;

  function automatic logic [CW-1:0] wrap_step(logic [CW-1:0] c, logic u, logic [CW-1:0] t);
    if (u) return (c >= t) ? '0 : c + 1'b1;
    return (c == '0) ? t : c - 1'b1;
  endfunction

  function automatic logic [DW-1:0] status_exp(logic [2:0] m);
    if (m == 3'd0 || m == 3'd5 || m == 3'd6) return DW'(m);
    return DW'(8);
  endfunction

  function automatic string mode_tag(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      3'd5: return "R4";
      3'd6: return "R5";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 3'd0; m_dir = 1'b0; m_top = '1; m_cnt = '0; m_armed = 1'b0;
      {t1, t2, t3, a1, a2, a3, b1, b2, b3} = '0;
    end else begin
      m_stp = 1'b0;
      m_up  = !m_dir;
      case (m_mode)
        3'd0: m_stp = 1'b1;
        3'd5: m_stp = t2;
        3'd6: m_stp = m_armed;
        3'd1: begin m_stp = (a2 != a3); m_up = (a2 != b2); end
        3'd2: begin m_stp = (b2 != b3); m_up = (a2 == b2); end
        3'd3: begin
          m_stp = (a2 != a3) ^ (b2 != b3);
          m_up  = (a2 != a3) ? (a2 != b2) : (a2 == b2);
        end
        default: ;
      endcase
      if (m_stp) m_cnt = wrap_step(m_cnt, m_up, m_top);
      if (cfg_we && cfg_addr == 2'd0)        m_armed = 1'b0;
      else if (m_mode == 3'd6 && t2 && !t3)  m_armed = 1'b1;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_mode = cfg_wdata[2:0];
          2'd1: m_dir  = cfg_wdata[0];
          2'd2: m_top  = cfg_wdata[CW-1:0];
          default: ;
        endcase
      end
      t3 = t2; t2 = t1; t1 = trig_in;
      a3 = a2; a2 = a1; a1 = enc_a;
      b3 = b2; b2 = b1; b1 = enc_b;
    end
  end

  // ---------------- checking helpers --------------------------------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp) check(count == m_cnt, mode_tag(m_mode), int'(count), int'(m_cnt));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic enc_to(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    cyc(4);
  endtask

  logic [CW-1:0] c0, c1;
  logic [DW-1:0] rv;

  initial begin
    void'($urandom(32'h5EED_0042));
    cyc(4);
    // R1: reset values, read while still in reset
    check(count == '0, "R1", int'(count), 0);
    rd(2'd0, rv); check(rv == '0, "R1", int'(rv), 0);
    rd(2'd1, rv); check(rv == '0, "R1", int'(rv), 0);
    rd(2'd2, rv); check(rv == 16'hFFFF, "R1", int'(rv), 65535);
    rd(2'd3, rv); check(rv == '0, "R1", int'(rv), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_cmp = 1'b1;

    // R2: free running up, then down
    c0 = count; cyc(3);
    check(count == c0 + 16'd3, "R2", int'(count), int'(c0 + 16'd3));
    wr(2'd1, 16'd1);
    c0 = count; cyc(2);
    check(count == c0 - 16'd2, "R2", int'(count), int'(c0 - 16'd2));

    // R3: wrap at a small top value, both directions
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd0);
    for (int i = 0; i < 8 && count != 16'd3; i++) cyc(1);
    cyc(1);
    check(count == '0, "R3", int'(count), 0);
    wr(2'd1, 16'd1);
    for (int i = 0; i < 8 && count != 16'd0; i++) cyc(1);
    cyc(1);
    check(count == 16'd3, "R3", int'(count), 3);

    // R4: level-gated counting
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'd5);
    c0 = count; cyc(4);
    check(count == c0, "R4", int'(count), int'(c0));
    trig_in = 1'b1;
    c0 = count; cyc(5);
    check(count == c0 + 16'd3, "R4", int'(count), int'(c0 + 16'd3));
    trig_in = 1'b0; cyc(4);
    c1 = count; cyc(4);
    check(count == c1, "R4", int'(count), int'(c1));

    // R5: edge-armed counting, second edge does not restart
    wr(2'd0, 16'd6);
    cyc(3); c0 = count; cyc(3);
    check(count == c0, "R5", int'(count), int'(c0));
    trig_in = 1'b1; cyc(1); trig_in = 1'b0; cyc(5);
    check(count == c0 + 16'd3, "R5", int'(count), int'(c0 + 16'd3));
    c1 = count;
    trig_in = 1'b1; cyc(1); trig_in = 1'b0; cyc(6);
    check(count == c1 + 16'd7, "R5", int'(count), int'(c1 + 16'd7));

    // R6: rewriting the same mode disarms
    wr(2'd0, 16'd6);
    c0 = count; cyc(4);
    check(count == c0, "R6", int'(count), int'(c0));

    // R9: quadrature forward, reverse, double change
    wr(2'd0, 16'd3);
    c0 = count;
    enc_to(1, 0); enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
    check(count == c0 + 16'd4, "R9", int'(count), int'(c0 + 16'd4));
    enc_to(0, 1); enc_to(1, 1); enc_to(1, 0); enc_to(0, 0);
    check(count == c0, "R9", int'(count), int'(c0));
    enc_to(1, 1); enc_to(0, 0);
    check(count == c0, "R9", int'(count), int'(c0));

    // R7: channel A only, direction bit set but ignored
    wr(2'd1, 16'd1);
    wr(2'd0, 16'd1);
    c0 = count;
    enc_to(1, 0); enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
    check(count == c0 + 16'd2, "R7", int'(count), int'(c0 + 16'd2));
    c1 = count; cyc(5);
    check(count == c1, "R7", int'(count), int'(c1));

    // R8: channel B only
    wr(2'd0, 16'd2);
    c0 = count;
    enc_to(1, 0); enc_to(1, 1); enc_to(0, 1); enc_to(0, 0);
    check(count == c0 + 16'd2, "R8", int'(count), int'(c0 + 16'd2));
    enc_to(0, 1); enc_to(1, 1); enc_to(1, 0); enc_to(0, 0);
    check(count == c0, "R8", int'(count), int'(c0));

    // R11: unused mode codes freeze the count
    wr(2'd0, 16'd4);
    c0 = count;
    trig_in = 1'b1; enc_to(1, 0); trig_in = 1'b0; enc_to(1, 1);
    check(count == c0, "R11", int'(count), int'(c0));
    wr(2'd0, 16'd7);
    c0 = count;
    trig_in = 1'b1; enc_to(0, 1); trig_in = 1'b0; enc_to(0, 0);
    check(count == c0, "R11", int'(count), int'(c0));

    // R10: status word in every mode value
    for (int m = 0; m < 8; m++) begin
      wr(2'd0, DW'(m));
      rd(2'd3, rv);
      check(rv == status_exp(3'(m)), "R10", int'(rv), int'(status_exp(3'(m))));
    end

    // random phase, checked cycle by cycle against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 100 < 15) trig_in = ~trig_in;
      case ($urandom % 10)
        0: enc_a = ~enc_a;
        1: enc_b = ~enc_b;
        2: if ($urandom % 20 == 0) begin enc_a = ~enc_a; enc_b = ~enc_b; end
        default: ;
      endcase
      if ($urandom % 30 == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 2'($urandom % 4);
        case (cfg_addr)
          2'd0: cfg_wdata = DW'($urandom % 8);
          2'd1: cfg_wdata = DW'($urandom % 2);
          2'd2: cfg_wdata = ($urandom % 4 == 0) ? DW'($urandom) : DW'($urandom % 24);
          default: cfg_wdata = DW'($urandom);
        endcase
      end else begin
        cfg_we = 1'b0;
        if (i % 7 == 0) begin
          rd(2'd3, rv);
          check(rv == status_exp(m_mode), "R10", int'(rv), int'(status_exp(m_mode)));
        end
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
    cyc(4);
    run_cmp = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule